// File: doc/BRIEF.md
# Bus-Clocked I2C Write Receiver

This block receives I2C write transfers as a slave and has no system clock. Its only timing sources are the bus wires themselves. A falling SDA with SCL high marks a START, and a rising SDA with SCL high marks a STOP. Two small registers catch these conditions by using SDA as their clock and SCL as their data. Each register is cleared asynchronously, so it is ready for the next bus event. Bits are shifted in on SCL rising edges. The control state machine moves on SCL falling edges, and the SDA pull-down also changes on those edges.

After a START, the block takes a 7-bit address and a direction bit. It acknowledges only its own address with a write direction. Every further byte is then presented on a byte output with a short strobe, and each one is acknowledged. A STOP sends the block back to idle at once. A repeated START restarts address reception. Pad logic outside the block is expected to make SDA reach the START/STOP detectors a little later than SCL. With that delay, a master that moves SDA at the same instant SCL falls does not create a false bus condition.

Top module: `i2c_busclk_rx`

## Requirements
- R1: While rstN is low, sdaPullEn, selected and byteStrobe are 0 and byteData is 0. Reset takes effect at once, also in the middle of a transfer.
- R2: A START is SDA falling while SCL is high. The next 8 SCL rising edges sample the address MSB first, followed by the direction bit, where 0 means write.
- R3: For a matching address with direction 0, selected rises at the 8th SCL falling edge after the START. sdaPullEn is high from that edge until the 9th falling edge.
- R4: For a non-matching address or direction 1, sdaPullEn stays 0 and selected stays 0 until the next START, and no byteStrobe occurs.
- R5: While selected, byteData loads each data byte MSB first at the byte's 8th SCL rising edge. byteStrobe is high from that edge until the next SCL falling edge, and low at all other times.
- R6: Every data byte received while selected is acknowledged: sdaPullEn is high from the byte's 8th SCL falling edge until its 9th falling edge.
- R7: Any number of data bytes may follow one address. byteData keeps the previous byte until the 8th rising edge of the next one.
- R8: A STOP (SDA rising while SCL is high) clears selected and releases SDA at once. SCL pulses after it are ignored until the next START.
- R9: A repeated START clears selected at the following SCL falling edge and restarts address reception. The new address alone decides whether the block is selected.
- R10: An SDA change made at the same instant SCL falls, reaching sdaIn after SCL is low, is not taken as a START or STOP. The bit is decoded normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level, arriving slightly after SCL |
| ownAddr | input | 7 | Address this receiver answers to |
| rstN | input | 1 | Asynchronous active-low reset |
| sdaPullEn | output | 1 | 1 pulls the data line low (open-drain drive) |
| byteStrobe | output | 1 | High while a newly received data byte is valid |
| byteData | output | 8 | Last received data byte |
| selected | output | 1 | 1 while this receiver is addressed for a write |

## Verification
The START/STOP detectors and the bit-advancing state machine can both be triggered at the same moment: when SDA moves at the very instant SCL falls. The bench provokes this on randomly chosen bytes, and on one directed transfer made of alternating bit patterns, by changing its SDA drive in the same time step as the SCL fall. A one-nanosecond line delay stands in for the pad delay. The result is judged by whether the acknowledge timing, the delivered byte values and the selected level all still match the bench's transfer model. A false START or STOP would break that model.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

  // control state, advanced on SCL falling edges
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } rxState_t;

  // strobes from control to datapath, read on SCL rising edges
  typedef struct packed {
    logic shiftEn;
    logic loadByte;
  } rxStrobe_t;

endpackage

// File: rtl/i2cs_bus_cond.sv
`timescale 1ns/1ps
module i2cs_bus_cond (
  input  logic sclIn,
  input  logic sdaIn,
  input  logic rstN,
  output logic busStart,
  output logic busStop
);

  logic startSeenQ;
  logic startClr;
  logic stopClr;

  // start flag lives until the first data rise has seen it
  assign startClr = !rstN || startSeenQ;
  // a new start wipes any standing stop
  assign stopClr  = !rstN || busStart;

  always_ff @(negedge sdaIn or posedge startClr) begin
    if (startClr) busStart <= 1'b0;
    else          busStart <= sclIn;
  end

  always_ff @(posedge sdaIn or posedge stopClr) begin
    if (stopClr) busStop <= 1'b0;
    else         busStop <= sclIn;
  end

  always_ff @(posedge sclIn or negedge rstN) begin
    if (!rstN) startSeenQ <= 1'b0;
    else       startSeenQ <= busStart;
  end

  AST_START_SHORT_LIVED: assert property (@(posedge sclIn) disable iff (!rstN)
    busStart |=> !busStart); // R2

endmodule

// File: rtl/i2cs_datapath.sv
`timescale 1ns/1ps
module i2cs_datapath import i2cs_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  output logic [BYTE_W-1:0] shiftByte,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteStrobe
);

  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] nextShift;
  logic              byteFlag;

  assign nextShift = {shiftReg[BYTE_W-2:0], sdaIn};
  assign shiftByte = shiftReg;

  always_ff @(posedge sclIn or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      byteData <= '0;
      byteFlag <= 1'b0;
    end else begin
      if (strb.shiftEn)  shiftReg <= nextShift;
      if (strb.loadByte) byteData <= nextShift;
      byteFlag <= strb.loadByte;
    end
  end

  // pulse spans the high phase of the last data bit
  assign byteStrobe = byteFlag && sclIn;

endmodule

// File: rtl/i2cs_ctrl.sv
`timescale 1ns/1ps
module i2cs_ctrl import i2cs_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic              sclIn,
  input  logic              rstN,
  input  logic              busStart,
  input  logic              busStop,
  input  logic [BYTE_W-1:0] shiftByte,
  input  logic [BYTE_W-2:0] ownAddr,
  output rxStrobe_t         strb,
  output logic              sdaPullEn,
  output logic              selected
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  rxState_t         state;
  logic [CNT_W-1:0] bitCnt;
  logic             fsmClr;
  logic             addrHit;
  logic             lastBit;

  assign fsmClr  = !rstN || busStop;
  assign lastBit = (bitCnt == LAST_BIT);
  assign addrHit = (shiftByte[BYTE_W-1:1] == ownAddr) && !shiftByte[0];

  always_ff @(negedge sclIn or posedge fsmClr) begin
    if (fsmClr) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      sdaPullEn <= 1'b0;
      selected  <= 1'b0;
    end else if (busStart) begin
      state     <= ST_ADDR;
      bitCnt    <= '0;
      sdaPullEn <= 1'b0;
      selected  <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (lastBit) begin
            state     <= ST_ADDR_ACK;
            bitCnt    <= '0;
            sdaPullEn <= addrHit;
            selected  <= addrHit;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_ADDR_ACK: begin
          sdaPullEn <= 1'b0;
          state     <= selected ? ST_DATA : ST_SKIP;
        end
        ST_DATA: begin
          if (lastBit) begin
            state     <= ST_DATA_ACK;
            bitCnt    <= '0;
            sdaPullEn <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_DATA_ACK: begin
          sdaPullEn <= 1'b0;
          state     <= ST_DATA;
        end
        default: begin
          state <= state;
        end
      endcase
    end
  end

  assign strb.shiftEn  = (state == ST_ADDR) || (state == ST_DATA);
  assign strb.loadByte = (state == ST_DATA) && lastBit;

  AST_PULL_NEEDS_SELECT: assert property (@(posedge sclIn) disable iff (fsmClr)
    sdaPullEn |-> selected); // R3

  AST_PULL_ONE_CLOCK: assert property (@(negedge sclIn) disable iff (fsmClr)
    $rose(sdaPullEn) |=> !sdaPullEn); // R6

endmodule

// File: rtl/i2c_busclk_rx.sv
`timescale 1ns/1ps
module i2c_busclk_rx import i2cs_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-2:0] ownAddr,
  input  logic              rstN,
  output logic              sdaPullEn,
  output logic              byteStrobe,
  output logic [BYTE_W-1:0] byteData,
  output logic              selected
);

  logic              busStart;
  logic              busStop;
  logic [BYTE_W-1:0] shiftByte;
  rxStrobe_t         strb;

  i2cs_bus_cond u_cond (
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .rstN     (rstN),
    .busStart (busStart),
    .busStop  (busStop)
  );

  i2cs_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .rstN       (rstN),
    .strb       (strb),
    .shiftByte  (shiftByte),
    .byteData   (byteData),
    .byteStrobe (byteStrobe)
  );

  i2cs_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .sclIn     (sclIn),
    .rstN      (rstN),
    .busStart  (busStart),
    .busStop   (busStop),
    .shiftByte (shiftByte),
    .ownAddr   (ownAddr),
    .strb      (strb),
    .sdaPullEn (sdaPullEn),
    .selected  (selected)
  );

  AST_STROBE_NEEDS_SELECT: assert property (@(negedge sclIn) disable iff (!rstN || busStop)
    byteStrobe |-> selected); // R5

  AST_QUIET_AFTER_STOP: assert property (@(negedge sclIn) disable iff (!rstN)
    busStop |-> (!selected && !sdaPullEn)); // R8

endmodule

// File: tb/i2c_busclk_rx_bench.sv
`timescale 1ns/1ps
module i2c_busclk_rx_bench;

  localparam int Q = 4;            // clk cycles per quarter SCL period
  localparam int WDOG = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclDrv = 1'b1;
  logic       mSdaLow = 1'b0;
  logic [6:0] ownAddr = 7'h3A;
  logic       sdaLine;
  logic       sdaPin;
  logic       sdaPullEn;
  logic       byteStrobe;
  logic [7:0] byteData;
  logic       selected;

  int   vecCnt = 0;
  int   errCnt = 0;
  bit   expSel = 1'b0;
  logic [7:0] lastByte = 8'h00;
  logic       seenStrobe;
  logic [7:0] seenData;

  always #5 clk = ~clk;

  // open-drain line; the pin sees it 1 ns late, as the pad delay would
  assign sdaLine = !(mSdaLow || sdaPullEn);
  assign #1 sdaPin = sdaLine;

  i2c_busclk_rx u_i2c_busclk_rx (
    .sclIn      (sclDrv),
    .sdaIn      (sdaPin),
    .ownAddr    (ownAddr),
    .rstN       (rstN),
    .sdaPullEn  (sdaPullEn),
    .byteStrobe (byteStrobe),
    .byteData   (byteData),
    .selected   (selected)
  );

  function automatic bit addrHit(input logic [7:0] v, input logic [6:0] a);
    return (v[7:1] == a) && !v[0];
  endfunction

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  endtask

  task automatic busStart();
    if (sclDrv) begin
      mSdaLow = 1'b1;
      tick(2 * Q);
      sclDrv = 1'b0;
    end else begin
      mSdaLow = 1'b0;
      tick(Q);
      sclDrv = 1'b1;
      tick(Q);
      mSdaLow = 1'b1;
      tick(Q);
      sclDrv = 1'b0;
    end
    expSel = 1'b0;
  endtask

  task automatic busStop();
    mSdaLow = 1'b1;
    tick(Q);
    sclDrv = 1'b1;
    tick(Q);
    mSdaLow = 1'b0;
    @(negedge clk);
    checkVal("R8 selected after stop", selected, 1'b0);
    checkVal("R8 pull after stop", sdaPullEn, 1'b0);
    expSel = 1'b0;
    tick(Q);
  endtask

  task automatic sendBit(input bit b, input bit sameEdge);
    if (sameEdge) mSdaLow = !b;
    tick(Q);
    if (!sameEdge) mSdaLow = !b;
    tick(Q);
    sclDrv = 1'b1;
    tick(Q);
    @(negedge clk);
    seenStrobe = byteStrobe;
    seenData = byteData;
    tick(Q);
    sclDrv = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, input bit isAddr, input bit sameEdge, input string extra);
    bit ack;
    bit strobeExp;
    string rq;
    string tg;
    tg = sameEdge ? {extra, " R10"} : extra;
    if (isAddr) begin
      ack = addrHit(v, ownAddr);
      rq = ack ? "R2 R3" : "R2 R4";
    end else begin
      ack = expSel;
      rq = expSel ? "R6" : "R4 no ack";
    end
    strobeExp = !isAddr && expSel;
    for (int i = 7; i >= 0; i--) begin
      sendBit(v[i], sameEdge);
      if (i == 4) begin
        checkVal({"R5 no early strobe", tg}, seenStrobe, 1'b0);
        checkVal({"R7 byte held", tg}, seenData, lastByte);
      end
      if (i == 0) begin
        checkVal({"R5 strobe", tg}, seenStrobe, strobeExp);
        if (strobeExp) checkVal({"R5 R7 byte value", tg}, seenData, v);
      end
    end
    if (isAddr) expSel = ack;
    if (strobeExp) lastByte = v;
    mSdaLow = 1'b0;
    tick(Q);
    @(negedge clk);
    checkVal({rq, " pull in ack", tg}, sdaPullEn, ack);
    checkVal({"R5 strobe ended", tg}, byteStrobe, 1'b0);
    checkVal({"R3 selected", tg}, selected, expSel);
    tick(Q);
    sclDrv = 1'b1;
    tick(Q);
    @(negedge clk);
    checkVal({rq, " line ack", tg}, !sdaPin, ack);
    tick(Q);
    sclDrv = 1'b0;
    tick(Q);
    @(negedge clk);
    checkVal({"R6 pull released", tg}, sdaPullEn, 1'b0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    tick(5);
    @(negedge clk);
    checkVal("R1 pull", sdaPullEn, 1'b0);
    checkVal("R1 selected", selected, 1'b0);
    checkVal("R1 strobe", byteStrobe, 1'b0);
    checkVal("R1 data", byteData, 8'h00);
    rstN = 1'b1;
    tick(4 * Q);

    // matching write, several bytes
    busStart();
    sendByte({ownAddr, 1'b0}, 1'b1, 1'b0, "");
    sendByte(8'hC3, 1'b0, 1'b0, " R7");
    sendByte(8'h01, 1'b0, 1'b0, " R7");
    sendByte(8'h80, 1'b0, 1'b0, " R7");
    busStop();

    // address differs only in its MSB
    busStart();
    sendByte({ownAddr ^ 7'h40, 1'b0}, 1'b1, 1'b0, " R4");
    sendByte(8'h55, 1'b0, 1'b0, " R4");
    busStop();

    // own address but read direction
    busStart();
    sendByte({ownAddr, 1'b1}, 1'b1, 1'b0, " R4");
    sendByte(8'hAA, 1'b0, 1'b0, " R4");
    busStop();

    // repeated start: selected, then other address, then own again
    busStart();
    sendByte({ownAddr, 1'b0}, 1'b1, 1'b0, " R9");
    sendByte(8'h3C, 1'b0, 1'b0, " R9");
    busStart();
    @(negedge clk);
    checkVal("R9 selected cleared", selected, 1'b0);
    sendByte({ownAddr ^ 7'h01, 1'b0}, 1'b1, 1'b0, " R9");
    sendByte(8'h99, 1'b0, 1'b0, " R9");
    busStart();
    sendByte({ownAddr, 1'b0}, 1'b1, 1'b0, " R9");
    sendByte(8'h66, 1'b0, 1'b0, " R9");

    // stop in the middle of a byte
    sendBit(1'b1, 1'b0);
    sendBit(1'b0, 1'b0);
    sendBit(1'b1, 1'b0);
    @(negedge clk);
    checkVal("R8 selected before stop", selected, 1'b1);
    busStop();
    // clocks with own address but no start are ignored
    sclDrv = 1'b0;
    sendByte({ownAddr, 1'b0}, 1'b0, 1'b0, " R8");
    sendByte(8'h5A, 1'b0, 1'b0, " R8");

    // data moved on the same instant SCL falls
    busStart();
    sendByte({ownAddr, 1'b0}, 1'b1, 1'b1, "");
    sendByte(8'hA5, 1'b0, 1'b1, "");
    sendByte(8'h5A, 1'b0, 1'b1, "");
    sendByte(8'hFF, 1'b0, 1'b1, "");
    sendByte(8'h00, 1'b0, 1'b1, "");
    busStop();

    // reset in the middle of a selected transfer
    busStart();
    sendByte({ownAddr, 1'b0}, 1'b1, 1'b0, " R1");
    rstN = 1'b0;
    @(negedge clk);
    checkVal("R1 selected on reset", selected, 1'b0);
    checkVal("R1 pull on reset", sdaPullEn, 1'b0);
    checkVal("R1 data on reset", byteData, 8'h00);
    lastByte = 8'h00;
    expSel = 1'b0;
    tick(2);
    rstN = 1'b1;
    sendByte(8'h77, 1'b0, 1'b0, " R1");
    busStop();

    // constrained random transfers
    for (int t = 0; t < 40; t++) begin
      logic [6:0] a;
      bit rw;
      int n;
      if ($urandom % 8 == 0) ownAddr = 7'($urandom);
      a = ($urandom % 2 == 1) ? ownAddr : 7'($urandom);
      rw = ($urandom % 5 == 0);
      busStart();
      sendByte({a, rw}, 1'b1, 1'($urandom % 2), " rnd");
      n = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) sendByte(8'($urandom), 1'b0, 1'($urandom % 2), " rnd R7");
      if ($urandom % 3 != 0) busStop();
    end
    if (!sclDrv) busStop();
    report();
  end

endmodule